// File: doc/BRIEF.md
# HDLC Receive FIFO with Packet-End Tagging

This block buffers bytes coming out of an HDLC receiver's deframing logic until a host reads them. Each stored byte carries a 2-bit tag. The tag marks whether the byte sits inside a packet or closes one, and if it closes one, how the packet ended: a good closing flag, an abort, or an invalid packet. The host reads from a show-ahead port. The current head byte and its tag are always visible, and a read request removes them.

Four sticky status bits tell the host about events. Each bit stays set until the host reads the status register:

- a packet end was stored;
- the byte at the head is the last byte of a packet, or the host tried to read an empty FIFO;
- a write pushed the fill level above a programmable threshold;
- a write arrived while the FIFO was full.

An overflow also turns the receiver off. The receiver is allowed to write again only after the deframer reports the next flag sequence.

Top module: `hdlc_rx_fifo`

## Requirements
- R1: Bytes and their tags leave `rd_data`/`rd_tag` in the order they were stored. The head entry is shown whenever `level` is non-zero. `level` rises by one for each stored byte and falls by one for each read of a non-empty FIFO, and a read and a write in the same cycle leave it unchanged.
- R2: After reset, `level` is 0, `rx_enable` is 1 and `irq_status` is 0.
- R3: If `wr_valid` is asserted while `rx_enable` is 1 and `level` equals DEPTH, the byte is dropped. This holds even if a read happens in the same cycle. `irq_status[3]` (overflow) is set and `rx_enable` drops on the next cycle.
- R4: While `rx_enable` is 0, writes are ignored: `level` does not change and no status bit is set. A `flag_seen` pulse sets `rx_enable` on the next cycle. If the FIFO is still full, a further write overflows again.
- R5: Storing a byte whose tag is not 00 sets `irq_status[0]`. The tag codes are 00 = mid-packet, 01 = good end, 10 = abort, 11 = invalid. Storing a byte with tag 00 leaves `irq_status[0]` unchanged.
- R6: `irq_status[1]` is set one cycle after a byte with a non-zero tag becomes the head. This covers a tagged byte written into an empty FIFO and a tagged byte exposed by a read, including one tagged byte exposed right after another. A tagged head that stays at the head does not set the bit again.
- R7: A read request while `level` is 0 sets `irq_status[1]` and leaves `level` at 0.
- R8: A stored byte that makes the level after the write strictly greater than `full_thr` sets `irq_status[2]`.
- R9: A cycle with `stat_rd` high clears every status bit. A bit whose event occurs in that same cycle remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Receiver offers a byte this cycle |
| wr_data | input | DW | Byte from the receiver |
| wr_tag | input | 2 | Packet-end code for the byte (R5) |
| flag_seen | input | 1 | Receiver detected a flag sequence |
| rx_enable | output | 1 | Receiver may write; low after overflow |
| rd_req | input | 1 | Host read of the FIFO head |
| rd_data | output | DW | Head byte |
| rd_tag | output | 2 | Head byte's tag |
| level | output | $clog2(DEPTH+1) | Current occupancy |
| full_thr | input | $clog2(DEPTH) | Fill threshold |
| stat_rd | input | 1 | Host read of the status register (clears it) |
| irq_status | output | 4 | [0] packet end stored, [1] last byte / empty read, [2] above threshold, [3] overflow |

## Verification
The bench builds the FIFO with DEPTH = 8 and DW = 8, so the threshold field is 3 bits wide. At that depth every threshold value can be combined with every fill level from 1 to 8. The full, overflow and re-enable sequence is also reached within a few cycles, and the sweep checks the above-threshold bit at all 64 pairs. Tag ordering, back-to-back tagged heads, empty reads and a status read that coincides with an event are each driven as a dedicated sequence.

// File: rtl/hdlc_rx_fifo_pkg.sv
// Package: shared tag codes and status bit positions for the HDLC receive FIFO.
package hdlc_rx_fifo_pkg;
    typedef enum logic [1:0] {
        TAG_MID     = 2'b00,
        TAG_GOOD    = 2'b01,
        TAG_ABORT   = 2'b10,
        TAG_INVALID = 2'b11
    } tag_e;

    localparam int ST_EOPW = 0;
    localparam int ST_LAST = 1;
    localparam int ST_FULL = 2;
    localparam int ST_OVF  = 3;
    localparam int ST_W    = 4;
endpackage

// File: rtl/hdlc_rx_fifo_store.sv
// Module: circular storage of data bytes and tags, with read/write pointers and occupancy.
// Assumes the caller never pushes when full and never pops when empty.
module hdlc_rx_fifo_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    parameter int TW    = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [DW-1:0]    wdata,
    input  logic [TW-1:0]    wtag,
    output logic [DW-1:0]    head_data,
    output logic [TW-1:0]    head_tag,
    output logic [CNT_W-1:0] level
);
    logic [DW-1:0]    data_mem [DEPTH];
    logic [TW-1:0]    tag_mem  [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Purpose: store the incoming byte and tag at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            data_mem[wptr] <= wdata;
            tag_mem[wptr]  <= wtag;
        end
    end

    // Purpose: advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push) wptr <= ptr_next(wptr);
            if (pop)  rptr <= ptr_next(rptr);
            level <= level + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Purpose: present the head entry (show-ahead).
    always_comb begin
        head_data = data_mem[rptr];
        head_tag  = tag_mem[rptr];
    end

    p_no_push_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level != CNT_W'(DEPTH)));
    p_no_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));
    p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (level == $past(level) + 1'b1));
endmodule

// File: rtl/hdlc_rx_fifo_gate.sv
// Module: receiver gate. Accepts writes when enabled and not full, detects overflow,
// disables the receiver on overflow and re-enables it on the next flag sequence.
module hdlc_rx_fifo_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_valid,
    input  logic full,
    input  logic flag_seen,
    output logic push,
    output logic overflow,
    output logic rx_enable
);
    // Purpose: classify an offered byte as stored or overflowing.
    always_comb begin
        push     = wr_valid && rx_enable && !full;
        overflow = wr_valid && rx_enable && full;
    end

    // Purpose: hold the receiver off from overflow until a flag is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_enable <= 1'b1;
        else if (overflow)  rx_enable <= 1'b0;
        else if (flag_seen) rx_enable <= 1'b1;
    end

    p_off_after_ovf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> !rx_enable);
    p_on_after_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_enable && flag_seen) |=> rx_enable);
    p_no_push_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> !push);
endmodule

// File: rtl/hdlc_rx_fifo_flags.sv
// Module: sticky status bits. Each bit is set by its event and cleared by a status read;
// an event in the read cycle wins. Assumes level/head_tag describe the FIFO state before this edge.
module hdlc_rx_fifo_flags
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [1:0]       push_tag,
    input  logic             pop,
    input  logic             overflow,
    input  logic             empty_rd,
    input  logic [CNT_W-1:0] level,
    input  logic [1:0]       head_tag,
    input  logic [THR_W-1:0] thr,
    input  logic             stat_rd,
    output logic [ST_W-1:0]  status
);
    logic             head_tagged, head_tagged_q, pop_q, head_evt;
    logic [CNT_W-1:0] level_after;
    logic [ST_W-1:0]  set_vec;

    // Purpose: detect a tagged byte newly arriving at the head.
    always_comb begin
        head_tagged = (level != '0) && (head_tag != TAG_MID);
        head_evt    = head_tagged && (!head_tagged_q || pop_q);
        level_after = level + CNT_W'(push) - CNT_W'(pop);
    end

    // Purpose: remember last cycle's head state and whether a pop exposed a new head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_tagged_q <= 1'b0;
            pop_q         <= 1'b0;
        end else begin
            head_tagged_q <= head_tagged;
            pop_q         <= pop;
        end
    end

    // Purpose: gather the set events for each status bit.
    always_comb begin
        set_vec          = '0;
        set_vec[ST_EOPW] = push && (push_tag != TAG_MID);
        set_vec[ST_LAST] = head_evt || empty_rd;
        set_vec[ST_FULL] = push && (int'(level_after) > int'(thr));
        set_vec[ST_OVF]  = overflow;
    end

    for (genvar b = 0; b < ST_W; b++) begin : g_sticky
        // Purpose: sticky bit with clear-on-read, set taking precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)            status[b] <= 1'b0;
            else if (set_vec[b])   status[b] <= 1'b1;
            else if (stat_rd)      status[b] <= 1'b0;
        end
    end

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> status[ST_OVF]);
    p_empty_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_rd |=> status[ST_LAST]);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !push && !pop && !overflow && !empty_rd && !head_evt) |=> (status == '0));
endmodule

// File: rtl/hdlc_rx_fifo.sv
// Module: HDLC receive FIFO top. Connects storage, receiver gate and status flags.
// Assumes the host reads via rd_req (show-ahead) and clears status via stat_rd.
module hdlc_rx_fifo
    import hdlc_rx_fifo_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [DW-1:0]    wr_data,
    input  logic [1:0]       wr_tag,
    input  logic             flag_seen,
    output logic             rx_enable,
    input  logic             rd_req,
    output logic [DW-1:0]    rd_data,
    output logic [1:0]       rd_tag,
    output logic [CNT_W-1:0] level,
    input  logic [THR_W-1:0] full_thr,
    input  logic             stat_rd,
    output logic [ST_W-1:0]  irq_status
);
    logic push, pop, overflow, empty_rd, full;

    // Purpose: split a host read into a pop or an empty read.
    always_comb begin
        full     = (level == CNT_W'(DEPTH));
        pop      = rd_req && (level != '0);
        empty_rd = rd_req && (level == '0);
    end

    hdlc_rx_fifo_gate u_gate (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .full(full),
        .flag_seen(flag_seen), .push(push), .overflow(overflow), .rx_enable(rx_enable)
    );

    hdlc_rx_fifo_store #(.DEPTH(DEPTH), .DW(DW), .TW(2)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(wr_data),
        .wtag(wr_tag), .head_data(rd_data), .head_tag(rd_tag), .level(level)
    );

    hdlc_rx_fifo_flags #(.CNT_W(CNT_W), .THR_W(THR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .push(push), .push_tag(wr_tag), .pop(pop),
        .overflow(overflow), .empty_rd(empty_rd), .level(level), .head_tag(rd_tag),
        .thr(full_thr), .stat_rd(stat_rd), .status(irq_status)
    );
endmodule

// File: tb/hdlc_rx_fifo_test.sv
module hdlc_rx_fifo_test;
    localparam int DEPTH = 8;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int THR_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, flag_seen = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_tag = '0;
    logic [THR_W-1:0] full_thr = '1;
    logic rx_enable;
    logic [7:0] rd_data;
    logic [1:0] rd_tag;
    logic [CNT_W-1:0] level;
    logic [3:0] irq_status;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hdlc_rx_fifo #(.DEPTH(DEPTH), .DW(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag),
        .flag_seen(flag_seen), .rx_enable(rx_enable), .rd_req(rd_req), .rd_data(rd_data),
        .rd_tag(rd_tag), .level(level), .full_thr(full_thr), .stat_rd(stat_rd),
        .irq_status(irq_status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [1:0] t);
        wr_valid = 1'b1; wr_data = d; wr_tag = t;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd();
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic rd_status(output logic [3:0] v);
        @(negedge clk);
        stat_rd = 1'b1;
        v = irq_status;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic pulse_flag();
        flag_seen = 1'b1;
        @(negedge clk);
        flag_seen = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        chk("R2 level", int'(level), 0);
        chk("R2 rx_enable", int'(rx_enable), 1);
        chk("R2 status", int'(irq_status), 0);

        // R1/R5: order of bytes and tags
        for (int i = 0; i < DEPTH; i++) begin
            wr(8'((i * 37) + 5), 2'(i % 4));
            chk("R1 level up", int'(level), i + 1);
        end
        rd_status(st);
        chk("R5 eop written", int'(st[0]), 1);
        chk("R3 no overflow yet", int'(st[3]), 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R1 head data", int'(rd_data), (i * 37 + 5) % 256);
            chk("R1 head tag", int'(rd_tag), i % 4);
            rd();
        end
        chk("R1 level drained", int'(level), 0);
        rd_status(st);

        // R1: simultaneous read and write keeps the level
        wr(8'h11, 2'b00);
        wr_valid = 1'b1; wr_data = 8'h22; wr_tag = 2'b00; rd_req = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0;
        chk("R1 level after rd+wr", int'(level), 1);
        chk("R1 head after rd+wr", int'(rd_data), 8'h22);
        rd();
        rd_status(st);

        // R5: mid-packet byte does not set packet-end bit
        wr(8'h3C, 2'b00);
        rd_status(st);
        chk("R5 mid byte no eop", int'(st[0]), 0);
        rd();
        rd_status(st);

        // R6: last-byte indication
        wr(8'h01, 2'b00); wr(8'h02, 2'b00); wr(8'h03, 2'b01);
        rd_status(st);
        chk("R6 untagged head", int'(st[1]), 0);
        rd(); rd();
        rd_status(st);
        chk("R6 tagged head exposed", int'(st[1]), 1);
        rd_status(st);
        chk("R6 no repeat while head stays", int'(st[1]), 0);
        rd();
        rd_status(st);
        wr(8'h04, 2'b10); wr(8'h05, 2'b11);
        rd_status(st);
        chk("R6 tagged into empty", int'(st[1]), 1);
        rd();
        rd_status(st);
        chk("R6 back-to-back tagged", int'(st[1]), 1);
        rd();
        rd_status(st);

        // R7: empty read
        rd();
        chk("R7 level stays 0", int'(level), 0);
        rd_status(st);
        chk("R7 empty read flag", int'(st[1]), 1);

        // R3/R4: overflow and recovery
        for (int i = 0; i < DEPTH; i++) wr(8'(i), 2'b00);
        rd_status(st);
        wr(8'hEE, 2'b00);
        chk("R3 rx disabled", int'(rx_enable), 0);
        chk("R3 level held", int'(level), DEPTH);
        rd_status(st);
        chk("R3 overflow flag", int'(st[3]), 1);
        wr(8'hEF, 2'b01);
        chk("R4 ignored write level", int'(level), DEPTH);
        rd_status(st);
        chk("R4 ignored write no flags", int'(st), 0);
        pulse_flag();
        chk("R4 re-enabled", int'(rx_enable), 1);
        wr(8'hF0, 2'b00);
        chk("R4 overflow again", int'(rx_enable), 0);
        rd_status(st);
        chk("R4 overflow again flag", int'(st[3]), 1);
        pulse_flag();
        // R3: write while full with a read in the same cycle is still dropped
        wr_valid = 1'b1; wr_data = 8'hF1; wr_tag = 2'b00; rd_req = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; rd_req = 1'b0;
        chk("R3 full rd+wr drops", int'(level), DEPTH - 1);
        chk("R3 full rd+wr disables", int'(rx_enable), 0);
        pulse_flag();
        wr(8'hF2, 2'b00);
        chk("R4 accepted after flag", int'(level), DEPTH);
        chk("R4 still enabled", int'(rx_enable), 1);
        for (int i = 0; i < DEPTH; i++) rd();
        rd_status(st);

        // R9: event in the status-read cycle survives; clear afterwards
        wr_valid = 1'b1; wr_data = 8'h77; wr_tag = 2'b01; stat_rd = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; stat_rd = 1'b0;
        chk("R9 same-cycle set kept", int'(irq_status[0]), 1);
        rd_status(st);
        chk("R9 read value", int'(st[1:0]), 3);
        rd_status(st);
        chk("R9 cleared", int'(st), 0);
        rd();
        rd_status(st);

        // R8: threshold sweep
        for (int t = 0; t < DEPTH; t++) begin
            full_thr = THR_W'(t);
            for (int k = 1; k <= DEPTH; k++) begin
                wr(8'(k), 2'b00);
                rd_status(st);
                chk($sformatf("R8 thr=%0d lvl=%0d", t, k), int'(st[2]), (k > t) ? 1 : 0);
            end
            for (int k = 0; k < DEPTH; k++) rd();
            rd_status(st);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule